// File: doc/BRIEF.md
# Quad DAC Batch Update Sequencer

This block sits between a four-lane amplitude datapath and a four-output serial DAC. Each lane delivers a signed 16-bit fixed-point sample with 14 fractional bits, and all four lanes share one valid strobe at the upstream sample rate. A decimating gate passes one sample in every `DECIM`. The four lane values of a passed sample are quantized to 16-bit unsigned DAC codes and captured together. The captured batch is then sent as four 24-bit write frames, channel 0 first. Each frame has its own chip-select window.

Once the last frame and its trailing gap are done, an active-low load strobe pulses once. The DAC then moves all four input registers to its outputs in the same instant. The default timing fits a 250 MHz system clock: SCLK runs at 25 MHz, and a full batch takes 992 cycles, which is about 3.97 µs. That fits the update period set by decimating a 20.48 MSPS stream by 82. If a sample passes the gate while a batch is still being sent, it is dropped and a saturating overrun count goes up.

Top module: `quad_dac_seq`

## Requirements
- R1: After reset, the first valid input sample passes the decimating gate. After that, exactly one valid sample in every `DECIM` (default 82) passes, and all other valid samples are dropped.
- R2: A passed sample is captured into the sequencer when it is idle. Input changes after that cycle do not change the data of the batch in flight.
- R3: Quantization of each signed Q2.14 lane value works as follows. A negative value gives code 0x0000. A value of 16384 (1.0) or more gives 0xFFFF. Any other value x gives code x*4.
- R4: Frames are sent MSB first, in channel order 0, 1, 2, 3. Bit layout: [23:22] = 00, [21:19] = register select (parameter, default 000), [18:17] = channel number, [16] = 0, [15:0] = code.
- R5: SCLK idles low and has a half-period of `SCLK_HALF` clocks (default 5). The data output changes only in the cycle where SCLK rises, and it holds steady through the high phase.
- R6: Chip-select goes low one SCLK half-period before the first rising edge of a frame. It goes high one half-period after the 24th falling edge, then stays high for `CS_GAP` clocks (default 2) before the next frame. SCLK is never high while chip-select is high.
- R7: After the gap that follows the fourth frame, the load strobe is driven low for `LOAD_W` clocks (default 4). It is never low while chip-select is low.
- R8: Busy rises in the cycle after a sample is captured. It stays high for 4*(49*SCLK_HALF+CS_GAP)+LOAD_W clocks (992 by default) and falls when the load strobe ends.
- R9: A sample that passes the gate while busy is high is dropped. It adds one to the overrun count, which saturates at 2^OVR_W-1 (255 by default).
- R10: During and after reset, the outputs are: chip-select high, SCLK low, data low, load strobe high, busy low, overrun count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_valid_i | input | 1 | Strobe: all four lanes carry a new sample |
| samp_i | input | 64 | Four signed Q2.14 lanes, lane n at bits [16n+15:16n] |
| sclk_o | output | 1 | Serial clock to the DAC |
| cs_no | output | 1 | Frame chip-select, active low |
| sdo_o | output | 1 | Serial data to the DAC |
| ldac_no | output | 1 | Load strobe that updates all outputs together, active low |
| busy_o | output | 1 | A batch is being sent |
| ovr_cnt_o | output | 8 | Saturating count of samples dropped for being busy |

## Verification
Almost every internal fault shows up at the serial pins in the same clock cycle. A stuck or miscounted timer shifts an SCLK edge or a chip-select edge by at least one cycle. A wrong bit index or channel index corrupts a data bit while SCLK is high, within one half-period of the fault. Two kinds of fault appear later. A decimation counter that is off by one only shows when the next batch starts, up to `DECIM` valid strobes later. A capture register that follows the inputs only corrupts data if the lanes change during a batch. For that reason the lanes are driven with fresh data on every cycle.

// File: rtl/qds_pkg.sv
package qds_pkg;
  localparam int FRAME_W = 24;
  localparam int DAC_W   = 16;
  localparam int ADDR_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_LOAD
  } qds_state_e;
endpackage

// File: rtl/qds_decim.sv
module qds_decim #(
  parameter int DECIM = 82
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic accept_o
);
  generate
    if (DECIM <= 1) begin : g_pass
      assign accept_o = valid_i;
    end else begin : g_count
      localparam int CW = $clog2(DECIM);
      localparam logic [CW-1:0] LAST = CW'(DECIM - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (valid_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign accept_o = valid_i && (cnt_q == '0);

      assert_one_in_a_row_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> !accept_o);
    end
  endgenerate
endmodule

// File: rtl/qds_quant.sv
module qds_quant #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 14,
  parameter int DAC_W  = 16
) (
  input  logic [IN_W-1:0]  samp_i,
  output logic [DAC_W-1:0] code_o
);
  localparam int SHIFT = DAC_W - FRAC_W;
  localparam logic [IN_W-1:0] ONE = IN_W'(1) << FRAC_W;

  always_comb begin
    if (samp_i[IN_W-1])    code_o = '0;       // negative clamps to zero
    else if (samp_i >= ONE) code_o = '1;      // 1.0 and above saturate
    else                    code_o = {samp_i[FRAC_W-1:0], {SHIFT{1'b0}}};
  end

  always_comb begin
    if (samp_i[IN_W-1])
      assert_neg_clamp_R3: assert (code_o == '0);
  end
endmodule

// File: rtl/qds_spi_eng.sv
module qds_spi_eng
  import qds_pkg::*;
#(
  parameter int         N_CH      = 4,
  parameter int         SCLK_HALF = 5,
  parameter int         CS_GAP    = 2,
  parameter int         LOAD_W    = 4,
  parameter logic [2:0] REG_SEL   = 3'b000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [N_CH*DAC_W-1:0] codes_i,
  output logic                  sclk_o,
  output logic                  cs_no,
  output logic                  sdo_o,
  output logic                  ldac_no,
  output logic                  busy_o
);
  localparam int MAXT = (SCLK_HALF > CS_GAP) ?
                        ((SCLK_HALF > LOAD_W) ? SCLK_HALF : LOAD_W) :
                        ((CS_GAP > LOAD_W) ? CS_GAP : LOAD_W);
  localparam int TW   = $clog2(MAXT + 1);
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [TW-1:0]   T_HALF = TW'(SCLK_HALF - 1);
  localparam logic [TW-1:0]   T_GAP  = TW'(CS_GAP - 1);
  localparam logic [TW-1:0]   T_LOAD = TW'(LOAD_W - 1);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(N_CH - 1);
  localparam logic [4:0]      TOP_BIT = 5'(FRAME_W - 1);

  qds_state_e        st_q;
  logic [TW-1:0]     cnt_q;
  logic [CH_W-1:0]   ch_q;
  logic [4:0]        bit_q;
  logic [DAC_W-1:0]  code_sel;
  logic [FRAME_W-1:0] frame;
  logic              tick;

  assign code_sel = codes_i[32'(ch_q)*DAC_W +: DAC_W];
  assign frame    = {2'b00, REG_SEL, ADDR_W'(ch_q), 1'b0, code_sel};
  assign busy_o   = (st_q != ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_GAP:  tick = (cnt_q == T_GAP);
      ST_LOAD: tick = (cnt_q == T_LOAD);
      default: tick = (cnt_q == T_HALF);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      bit_q   <= TOP_BIT;
      sclk_o  <= 1'b0;
      cs_no   <= 1'b1;
      sdo_o   <= 1'b0;
      ldac_no <= 1'b1;
    end else begin
      if (st_q == ST_IDLE || tick) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_LEAD;
          cs_no <= 1'b0;
          ch_q  <= '0;
          bit_q <= TOP_BIT;
        end
        ST_LEAD: if (tick) begin
          st_q   <= ST_HIGH;
          sclk_o <= 1'b1;
          sdo_o  <= frame[bit_q];
        end
        ST_HIGH: if (tick) begin
          st_q   <= ST_LOW;
          sclk_o <= 1'b0;
        end
        ST_LOW: if (tick) begin
          if (bit_q == '0) begin
            st_q  <= ST_GAP;
            cs_no <= 1'b1;
          end else begin
            st_q   <= ST_HIGH;
            bit_q  <= bit_q - 1'b1;
            sclk_o <= 1'b1;
            sdo_o  <= frame[bit_q - 1'b1];
          end
        end
        ST_GAP: if (tick) begin
          if (ch_q == CH_LAST) begin
            st_q    <= ST_LOAD;
            ldac_no <= 1'b0;
          end else begin
            st_q  <= ST_LEAD;
            ch_q  <= ch_q + 1'b1;
            bit_q <= TOP_BIT;
            cs_no <= 1'b0;
          end
        end
        ST_LOAD: if (tick) begin
          st_q    <= ST_IDLE;
          ldac_no <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_in_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  assert_cs_lead_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sclk_o);
  assert_sdo_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sclk_o) |-> $stable(sdo_o));
  assert_load_outside_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_no |-> cs_no);
endmodule

// File: rtl/quad_dac_seq.sv
module quad_dac_seq
  import qds_pkg::*;
#(
  parameter int         N_CH      = 4,
  parameter int         IN_W      = 16,
  parameter int         FRAC_W    = 14,
  parameter int         DECIM     = 82,
  parameter int         SCLK_HALF = 5,
  parameter int         CS_GAP    = 2,
  parameter int         LOAD_W    = 4,
  parameter int         OVR_W     = 8,
  parameter logic [2:0] REG_SEL   = 3'b000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 samp_valid_i,
  input  logic [N_CH*IN_W-1:0] samp_i,
  output logic                 sclk_o,
  output logic                 cs_no,
  output logic                 sdo_o,
  output logic                 ldac_no,
  output logic                 busy_o,
  output logic [OVR_W-1:0]     ovr_cnt_o
);
  logic                  accept;
  logic                  start;
  logic [N_CH*DAC_W-1:0] code_d;
  logic [N_CH*DAC_W-1:0] code_q;

  qds_decim #(.DECIM(DECIM)) u_decim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (samp_valid_i),
    .accept_o (accept)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_lane
      qds_quant #(.IN_W(IN_W), .FRAC_W(FRAC_W), .DAC_W(DAC_W)) u_quant (
        .samp_i (samp_i[i*IN_W +: IN_W]),
        .code_o (code_d[i*DAC_W +: DAC_W])
      );
    end
  endgenerate

  assign start = accept && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (start) code_q <= code_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_cnt_o <= '0;
    else if (accept && busy_o && ovr_cnt_o != '1) ovr_cnt_o <= ovr_cnt_o + 1'b1;
  end

  qds_spi_eng #(
    .N_CH(N_CH), .SCLK_HALF(SCLK_HALF), .CS_GAP(CS_GAP),
    .LOAD_W(LOAD_W), .REG_SEL(REG_SEL)
  ) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .codes_i (code_q),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .sdo_o   (sdo_o),
    .ldac_no (ldac_no),
    .busy_o  (busy_o)
  );

  assert_batch_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(code_q));
  assert_ovr_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && busy_o && ovr_cnt_o != '1) |=> ovr_cnt_o == $past(ovr_cnt_o) + 1'b1);
  assert_ovr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept && busy_o) |=> $stable(ovr_cnt_o));
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o && !cs_no);
endmodule

// File: tb/tb_quad_dac_seq.sv
`timescale 1ns/1ps
module tb_quad_dac_seq;
  localparam int DECIM = 82;
  localparam int H     = 5;
  localparam int G     = 2;
  localparam int W     = 4;
  localparam int FR    = 49 * H + G;
  localparam int TOTAL = 4 * FR + W;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        samp_valid_i = 1'b0;
  logic [63:0] samp_i = '0;
  logic        sclk_o, cs_no, sdo_o, ldac_no, busy_o;
  logic [7:0]  ovr_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_dcnt = 0;
  int m_rel  = -1;
  int m_ovr  = 0;
  logic [15:0] m_code [4];

  always #2 clk = ~clk;

  quad_dac_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .samp_valid_i(samp_valid_i), .samp_i(samp_i),
    .sclk_o(sclk_o), .cs_no(cs_no), .sdo_o(sdo_o), .ldac_no(ldac_no),
    .busy_o(busy_o), .ovr_cnt_o(ovr_cnt_o)
  );

  function automatic logic [15:0] quant(input logic [15:0] x);
    if (x[15]) return 16'h0000;
    if (x >= 16'd16384) return 16'hFFFF;
    return 16'(int'(x) * 4);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_cs = 1, e_sclk = 0, e_ldac = 1, e_sdo = -1;
    if (m_rel >= 0) begin
      if (m_rel < 4 * FR) begin
        int f = m_rel / FR;
        int o = m_rel % FR;
        if (o < 49 * H) begin
          e_cs = 0;
          if (o >= H) begin
            int q = o - H;
            int b = 23 - q / (2 * H);
            if ((q % (2 * H)) < H) begin
              logic [23:0] fr = {2'b00, 3'b000, 2'(f), 1'b0, m_code[f]};
              e_sclk = 1;
              e_sdo  = int'(fr[b]);
            end
          end
        end
      end else begin
        e_ldac = 0;
      end
    end
    chk("R6 cs", int'(cs_no), e_cs);
    chk("R5 sclk", int'(sclk_o), e_sclk);
    chk("R7 load", int'(ldac_no), e_ldac);
    chk("R1 R8 busy", int'(busy_o), (m_rel >= 0) ? 1 : 0);
    chk("R9 ovr", int'(ovr_cnt_o), m_ovr);
    if (e_sdo >= 0) chk("R2 R3 R4 sdo", int'(sdo_o), e_sdo);
  endtask

  task automatic step(input bit v, input logic [63:0] d);
    bit acc, busy_prev;
    samp_valid_i = v;
    samp_i = d;
    acc = v && (m_dcnt == 0);
    if (v) m_dcnt = (m_dcnt + 1) % DECIM;
    busy_prev = (m_rel >= 0);
    if (busy_prev) begin
      m_rel++;
      if (m_rel == TOTAL) m_rel = -1;
    end
    if (acc) begin
      if (busy_prev) begin
        if (m_ovr < 255) m_ovr++;
      end else begin
        for (int i = 0; i < 4; i++) m_code[i] = quant(d[16*i +: 16]);
        m_rel = 0;
      end
    end
    @(negedge clk);
    compare();
  endtask

  function automatic logic [63:0] rnd_lanes();
    logic [63:0] r;
    for (int i = 0; i < 4; i++) begin
      case ($urandom_range(0, 3))
        0: r[16*i +: 16] = 16'($urandom_range(16'h8000, 16'hFFFF));
        1: r[16*i +: 16] = 16'($urandom_range(16384, 32767));
        default: r[16*i +: 16] = 16'($urandom_range(0, 16383));
      endcase
    end
    return r;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_code[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cs", int'(cs_no), 1);
    chk("R10 sclk", int'(sclk_o), 0);
    chk("R10 sdo", int'(sdo_o), 0);
    chk("R10 load", int'(ldac_no), 1);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 ovr", int'(ovr_cnt_o), 0);
    rst_ni = 1'b1;
    step(1'b0, '0);

    // R3 corners in first batch: -1, 1.0, max below 1.0, max positive
    step(1'b1, {16'h7FFF, 16'd16383, 16'd16384, 16'hFFFF});
    for (int c = 0; c < 12 * DECIM * 3; c++)
      step((c % 13) == 12, rnd_lanes());

    repeat (200) step(1'b0, rnd_lanes());

    // R9 overruns with a dense valid stream, then spacing just under a batch
    for (int c = 0; c < 2500; c++) step(1'b1, rnd_lanes());
    for (int c = 0; c < 12 * DECIM * 6; c++)
      step((c % 12) == 0, rnd_lanes());

    // R9 saturation of the overrun count
    for (int c = 0; c < 28000; c++) step(1'b1, rnd_lanes());
    repeat (1200) step(1'b0, '0);
    chk("R9 saturated", int'(ovr_cnt_o), 255);

    finish_run();
  end
endmodule